// File: doc/BRIEF.md
# Read handshake controller

This block sits between a bus master and a slow device during a read. The master raises a request and waits for a bus acknowledge. The controller raises a strobe towards the device and waits for the device acknowledge. It then opens the data latch and acknowledges the master. Both sides follow a four-phase return-to-zero protocol.

The return phase is interleaved. Once the master withdraws its request, the controller closes the latch. It then drops the bus acknowledge, and after that the device strobe. The device may then release its acknowledge. A new request is legal as soon as the bus acknowledge is low, while the device side may still be returning to zero.

During that overlap, one state (strobe high, latch closed, bus acknowledge low, device acknowledge high) looks the same at every signal as the state where the strobe has just risen and the device has answered. An internal phase bit tells the two apart.

Both inputs are synchronised before use. Every output is registered.

A mode input selects how the next strobe is raised:
- In the default safe mode, the controller waits for the device acknowledge to be low before it raises the next strobe.
- In the early mode, it raises the strobe as soon as the request arrives. It flags a timing violation if the device acknowledge is still high at that moment.

A protocol-error pulse reports any input edge that the current state does not allow.

Top module: `rd_xfer_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, `dev_stb`, `latch_en`, `bus_ack`, `timing_viol` and `proto_err` are low, and the block waits for a request.
- R2: With `dev_ack_in` low, a rise of `req_in` driven before clock edge k raises `dev_stb` after edge k+2 and not earlier (two synchroniser stages plus one state register).
- R3: With `dev_stb` high, a rise of `dev_ack_in` before edge k raises `latch_en` after edge k+2, and `bus_ack` follows one clock later. `bus_ack` never rises unless `latch_en` and `dev_stb` are high.
- R4: With `bus_ack` high, a fall of `req_in` before edge k lowers `latch_en` after edge k+2. `bus_ack` falls one clock later, and `dev_stb` one clock after that. `dev_stb` never falls while `latch_en` or `bus_ack` is high.
- R5: At most one of the three outputs changes per clock. Over back-to-back reads, the observed order is: request up, strobe up, device ack up, latch up, bus ack up, request down, latch down, bus ack down, then strobe down before device ack down.
- R6: With `early_stb` = 0, `dev_stb` does not rise while the synchronised `dev_ack_in` is still high, even with a request pending. It rises once the acknowledge is low.
- R7: With `early_stb` = 1, a pending request raises `dev_stb` even while `dev_ack_in` is high, and `timing_viol` pulses high for one clock in that case.
- R8: `timing_viol` stays low with `early_stb` = 0. It also stays low in early mode when the device acknowledge falls before the next request.
- R9: A fall of `req_in` before `bus_ack` has risen raises `proto_err` within four clocks.
- R10: A rise of `dev_ack_in` while `dev_stb` is low raises `proto_err` within four clocks.
- R11: `proto_err` stays low throughout legal back-to-back read traffic in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| early_stb | input | 1 | 1 = raise strobe without waiting for device ack low |
| req_in | input | 1 | Master read request (asynchronous) |
| dev_ack_in | input | 1 | Device acknowledge (asynchronous) |
| dev_stb | output | 1 | Strobe to the device |
| latch_en | output | 1 | Data latch enable |
| bus_ack | output | 1 | Acknowledge to the master |
| timing_viol | output | 1 | One-clock pulse: early-mode assumption broken |
| proto_err | output | 1 | One-clock pulse: input edge not enabled in current state |

## Verification
A wrong phase bit shows up within one clock of the bus acknowledge falling. If the bit is lost, the controller treats the device acknowledge as a fresh answer and reopens the latch instead of dropping the strobe. The event-order monitor catches this as an out-of-sequence latch rise on the very next sample. A wrong return-phase state shows as two outputs moving in one clock, or as the strobe falling ahead of the bus acknowledge, both seen at the ports in the cycle they happen. Exact latencies are checked at the cycle where each output must change and at the cycle before it.

// File: rtl/rd_xfer_ctrl.sv
module rd_xfer_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic early_stb,
  input  logic req_in,
  input  logic dev_ack_in,
  output logic dev_stb,
  output logic latch_en,
  output logic bus_ack,
  output logic timing_viol,
  output logic proto_err
);

  localparam int SL = SYNC_STAGES - 1;

  logic [SL:0] req_sy, ack_sy;
  logic req_s, ack_s, req_q, ack_q;
  logic stb_q, lat_q, back_q, phase_q;
  logic stb_n, lat_n, back_n, phase_n, viol_n, err_n;
  logic req_rise, req_fall, ack_rise, ack_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_sy <= '0;
      ack_sy <= '0;
      req_q  <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      req_sy <= {req_sy[SL-1:0], req_in};
      ack_sy <= {ack_sy[SL-1:0], dev_ack_in};
      req_q  <= req_s;
      ack_q  <= ack_s;
    end
  end

  assign req_s    = req_sy[SL];
  assign ack_s    = ack_sy[SL];
  assign req_rise = req_s & ~req_q;
  assign req_fall = ~req_s & req_q;
  assign ack_rise = ack_s & ~ack_q;
  assign ack_fall = ~ack_s & ack_q;

  always_comb begin
    stb_n   = stb_q;
    lat_n   = lat_q;
    back_n  = back_q;
    phase_n = phase_q;
    viol_n  = 1'b0;
    case ({stb_q, lat_q, back_q, phase_q})
      4'b0000: if (req_s && (early_stb || !ack_s)) begin
        stb_n  = 1'b1;
        viol_n = early_stb & ack_s;
      end
      4'b1000: if (ack_s) begin
        lat_n   = 1'b1;
        phase_n = 1'b1;
      end
      4'b1101: back_n = 1'b1;
      4'b1111: if (!req_s) lat_n = 1'b0;
      4'b1011: back_n = 1'b0;
      4'b1001: begin
        stb_n   = 1'b0;
        phase_n = 1'b0;
      end
      default: begin
        stb_n   = 1'b0;
        lat_n   = 1'b0;
        back_n  = 1'b0;
        phase_n = 1'b0;
      end
    endcase
  end

  assign err_n = (req_fall & ~back_q) | (req_rise & back_q) |
                 (ack_rise & ~stb_q) |
                 (ack_fall & stb_q & (lat_q | back_q | phase_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_q       <= 1'b0;
      lat_q       <= 1'b0;
      back_q      <= 1'b0;
      phase_q     <= 1'b0;
      timing_viol <= 1'b0;
      proto_err   <= 1'b0;
    end else begin
      stb_q       <= stb_n;
      lat_q       <= lat_n;
      back_q      <= back_n;
      phase_q     <= phase_n;
      timing_viol <= viol_n;
      proto_err   <= err_n;
    end
  end

  assign dev_stb  = stb_q;
  assign latch_en = lat_q;
  assign bus_ack  = back_q;

  // R5
  one_output_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({dev_stb ^ $past(dev_stb), latch_en ^ $past(latch_en),
                bus_ack ^ $past(bus_ack)}) <= 1);

  // R3
  ack_after_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ack) |-> (latch_en && dev_stb));

  // R4
  strobe_drop_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_stb) |-> (!latch_en && !bus_ack));

  // R2
  strobe_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_stb) |-> $past(req_s));

  // R6
  safe_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dev_stb) && !early_stb) |-> !$past(ack_s));

  // R8
  viol_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timing_viol |-> $past(early_stb));

endmodule

// File: tb/rd_xfer_ctrl_test.sv
`timescale 1ns/1ps
module rd_xfer_ctrl_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic early_stb = 1'b0;
  logic req_in = 1'b0;
  logic dev_ack_in = 1'b0;
  logic dev_stb, latch_en, bus_ack, timing_viol, proto_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit mon_en = 0, dev_auto = 0;
  int dev_max = 3;
  logic [4:0] pv = '0;
  int pos = 0;
  bit tail = 0, sdone = 0, perr_seen = 0, tv_seen = 0;

  always #4 clk = ~clk;

  rd_xfer_ctrl uut (
    .clk(clk), .rst_n(rst_n), .early_stb(early_stb), .req_in(req_in),
    .dev_ack_in(dev_ack_in), .dev_stb(dev_stb), .latch_en(latch_en),
    .bus_ack(bus_ack), .timing_viol(timing_viol), .proto_err(proto_err)
  );

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", r, act, exp, $time);
    end
  endtask

  // event code -> bit of {req, ack, stb, lat, back} and direction
  function automatic int ev_bit(input int e);
    case (e)
      0, 5: return 4;
      1, 8: return 2;
      2, 9: return 3;
      3, 6: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit ev_dir(input int e);
    return (e < 5);
  endfunction

  function automatic int next_pos(input int p);
    return (p + 1) % 8;
  endfunction

  always @(negedge clk) begin
    logic [4:0] cur;
    int nout;
    cur = {req_in, dev_ack_in, dev_stb, latch_en, bus_ack};
    if (mon_en) begin
      if (proto_err) perr_seen = 1;
      if (timing_viol) tv_seen = 1;
      nout = int'(cur[2] != pv[2]) + int'(cur[1] != pv[1]) + int'(cur[0] != pv[0]);
      if (nout != 0) chk(nout <= 1, "R5 one output per clock", nout, 1);
      for (int e = 0; e < 10; e++) begin
        if (cur[ev_bit(e)] != pv[ev_bit(e)] && cur[ev_bit(e)] == ev_dir(e)) begin
          if (e < 8) begin
            chk(e == pos, "R5 event order", e, pos);
            pos = next_pos(pos);
            if (e == 1) begin
              chk(!sdone, "R5 strobe up after previous strobe down", sdone, 0);
              if (!early_stb) chk(!tail, "R6 strobe waits for device ack low", tail, 0);
            end
            if (e == 7) sdone = 1;
          end else if (e == 8) begin
            chk(sdone, "R4 strobe down after bus ack down", sdone, 1);
            sdone = 0;
            tail = 1;
          end else begin
            chk(tail, "R5 device ack down after strobe down", tail, 1);
            tail = 0;
          end
        end
      end
    end
    pv = cur;
  end

  initial begin
    forever begin
      @(negedge clk);
      if (dev_auto) begin
        if (dev_stb && !dev_ack_in) begin
          repeat ($urandom_range(0, dev_max)) @(negedge clk);
          #1 dev_ack_in = 1'b1;
        end else if (!dev_stb && dev_ack_in) begin
          repeat ($urandom_range(0, dev_max)) @(negedge clk);
          #1 dev_ack_in = 1'b0;
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    #1;
    rst_n = 1'b0; req_in = 1'b0; dev_ack_in = 1'b0;
    cyc(4);
    #1 rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_for(input bit want_ack, input bit lvl, input string r);
    int n = 0;
    while (((want_ack ? bus_ack : dev_stb) != lvl) && n < 60) begin
      @(negedge clk);
      n++;
    end
    chk(n < 60, r, n, 60);
  endtask

  task automatic pulse_within(input bit which_err, input int n, input string r);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (which_err ? proto_err : timing_viol) seen = 1;
    end
    chk(seen, r, seen, 1);
  endtask

  task automatic xfer(input int lo, input int hi);
    #1 req_in = 1'b1;
    wait_for(1, 1, "R3 bus ack rises");
    cyc($urandom_range(0, 3));
    #1 req_in = 1'b0;
    wait_for(1, 0, "R4 bus ack falls");
    cyc($urandom_range(lo, hi));
  endtask

  task automatic random_phase(input bit mode, input int n, input int dmax,
                              input int lo, input int hi);
    early_stb = mode;
    do_reset();
    dev_max = dmax;
    pos = 0; tail = 0; sdone = 0; perr_seen = 0; tv_seen = 0;
    pv = '0;
    dev_auto = 1;
    mon_en = 1;
    for (int i = 0; i < n; i++) xfer(lo, hi);
    cyc(20);
    mon_en = 0;
    dev_auto = 0;
    chk(pos == 0, "R5 all transfers completed", pos, 0);
    chk(!tail && !sdone, "R5 return phase completed", {tail, sdone}, 0);
    chk(!perr_seen, "R11 no protocol error in legal traffic", perr_seen, 0);
    chk(!tv_seen, "R8 no timing violation", tv_seen, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4713));

    // R1: reset state
    cyc(2);
    chk({dev_stb, latch_en, bus_ack, timing_viol, proto_err} == 5'b0,
        "R1 outputs low in reset", {dev_stb, latch_en, bus_ack, timing_viol, proto_err}, 0);
    do_reset();
    cyc(3);
    chk({dev_stb, latch_en, bus_ack, timing_viol, proto_err} == 5'b0,
        "R1 idle after reset", {dev_stb, latch_en, bus_ack, timing_viol, proto_err}, 0);

    // R2..R4 exact latencies
    #1 req_in = 1'b1;
    cyc(2);
    chk(!dev_stb, "R2 strobe not before edge k+2", dev_stb, 0);
    cyc(1);
    chk(dev_stb, "R2 strobe after edge k+2", dev_stb, 1);
    #1 dev_ack_in = 1'b1;
    cyc(2);
    chk(!latch_en, "R3 latch not early", latch_en, 0);
    cyc(1);
    chk(latch_en && !bus_ack, "R3 latch after edge k+2", {latch_en, bus_ack}, 2);
    cyc(1);
    chk(bus_ack, "R3 bus ack one clock after latch", bus_ack, 1);
    #1 req_in = 1'b0;
    cyc(2);
    chk(latch_en, "R4 latch held until edge k+2", latch_en, 1);
    cyc(1);
    chk(!latch_en && bus_ack, "R4 latch drops first", {latch_en, bus_ack}, 1);
    cyc(1);
    chk(!bus_ack && dev_stb, "R4 bus ack drops next", {bus_ack, dev_stb}, 1);
    cyc(1);
    chk(!dev_stb, "R4 strobe drops last", dev_stb, 0);
    #1 dev_ack_in = 1'b0;
    cyc(6);
    chk(!proto_err, "R11 clean directed cycle", proto_err, 0);

    // R10 / R6: ack raised with strobe low, then request in safe mode
    do_reset();
    #1 dev_ack_in = 1'b1;
    pulse_within(1, 4, "R10 protocol error on unsolicited device ack");
    #1 req_in = 1'b1;
    cyc(8);
    chk(!dev_stb, "R6 strobe held while device ack high", dev_stb, 0);
    chk(!timing_viol, "R8 no violation in safe mode", timing_viol, 0);
    #1 dev_ack_in = 1'b0;
    cyc(3);
    chk(dev_stb, "R6 strobe rises once device ack low", dev_stb, 1);

    // R7: early mode with device ack still high
    early_stb = 1'b1;
    do_reset();
    #1 dev_ack_in = 1'b1;
    cyc(4);
    #1 req_in = 1'b1;
    cyc(2);
    chk(!timing_viol && !dev_stb, "R7 no flag before request seen", {timing_viol, dev_stb}, 0);
    cyc(1);
    chk(dev_stb && timing_viol, "R7 strobe and violation pulse", {dev_stb, timing_viol}, 3);
    cyc(1);
    chk(!timing_viol, "R7 violation is one clock", timing_viol, 0);
    early_stb = 1'b0;

    // R9: request withdrawn before bus ack
    do_reset();
    #1 req_in = 1'b1;
    cyc(3);
    #1 req_in = 1'b0;
    pulse_within(1, 4, "R9 protocol error on early request drop");
    do_reset();

    // R5, R6, R8, R11: random back-to-back reads in both modes
    random_phase(1'b0, 30, 5, 1, 4);
    random_phase(1'b1, 30, 2, 7, 10);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule